// File: doc/BRIEF.md
# Variable Rotate-Left Unit with Status Flags

The unit rotates an operand of 8, 16, 32 or 64 bits to the left by a variable count. Bits that leave the top of the selected operand width come back in at bit 0. Alongside the rotated value it produces a new carry flag and a new overflow flag under processor-style rules. A flags-write enable tells the consumer whether the flags are to be committed. An overflow-undefined indicator marks the cases where the overflow value carries no architectural meaning.

The count arrives as an 8-bit value and is masked according to the operand size before use. For the 8- and 16-bit sizes the masked count can exceed the operand width. In that case the data moves by the masked count modulo the width, while the flag rules still follow the masked count. Every request with `valid_i` high is accepted. The rotated result and the flags appear, registered, on the following cycle with `valid_o` high.

Top module: `rol_flag_unit`

## Requirements
- R1: The result's low W bits equal the low W bits of `operand_i` rotated left, where W is selected by `size_i`: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. A bit that leaves bit W-1 re-enters at bit 0.
- R2: The masked count keeps bits 4:0 of `count_i` when `size_i` is 0, 1 or 2, and keeps bits 5:0 when `size_i` is 3.
- R3: For the 8- and 16-bit sizes the rotation amount is the masked count modulo W. A masked count of 8 on an 8-bit operand therefore returns the operand unchanged.
- R4: Result bits at and above W are zero.
- R5: When the masked count is nonzero, `flags_we_o` is 1 and `carry_o` equals bit 0 of the result.
- R6: When the masked count is exactly 1, `ovf_o` equals `carry_o` XOR result bit W-1, and `ovf_undef_o` is 0.
- R7: When the masked count is greater than 1, `ovf_undef_o` is 1 and `ovf_o` equals `ovf_i` of the request.
- R8: When the masked count is 0, `flags_we_o` and `ovf_undef_o` are 0, and `carry_o` and `ovf_o` equal the request's `carry_i` and `ovf_i`.
- R9: `valid_o` is 1 exactly in the cycle after a cycle with `valid_i` high. All data and flag outputs hold their values while `valid_i` is low.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| operand_i | input | 64 | Value to rotate; bits above the selected size are ignored |
| size_i | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| count_i | input | 8 | Raw rotate count |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Rotated value, zero above the selected size |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| flags_we_o | output | 1 | Flags are to be written |
| ovf_undef_o | output | 1 | Overflow value is architecturally undefined |

## Verification
The hardest cases to reach are the ones where the raw count is nonzero but the masked count is zero, or where the masked count is a nonzero multiple of the 8- or 16-bit width. In the first case the flags must not be written. In the second the data comes back unchanged but the flags must still be written. Sweeping every raw count from 0 to 255 against every size reaches all of these cases with several operands each. The operands include garbage in the bits above the selected size. The expected values come from an arithmetic shift-and-or model of the rotation.

// File: rtl/rol_flag_pkg.sv
package rol_flag_pkg;
  localparam int MAX_W  = 64;
  localparam int MIN_W  = 8;
  localparam int CNT_W  = 8;
  localparam int NUM_SZ = 4;
  localparam int SZ_W   = $clog2(NUM_SZ);
  localparam int MCNT_W = $clog2(MAX_W);

  typedef enum logic [SZ_W-1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } size_e;

  function automatic int unsigned size_bits(size_e s);
    return MIN_W << s;
  endfunction
endpackage

// File: rtl/rol_count_mask.sv
module rol_count_mask
  import rol_flag_pkg::*;
(
  input  size_e             size_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [MCNT_W-1:0] masked_o,
  output logic [MCNT_W-1:0] amt_o
);
  logic [MCNT_W-1:0] width_mask;

  always_comb begin
    if (size_i == SZ_B64) masked_o = count_i[MCNT_W-1:0];
    else                  masked_o = {1'b0, count_i[MCNT_W-2:0]};
    width_mask = MCNT_W'(size_bits(size_i) - 1);
    // modulo width for narrow sizes
    amt_o = masked_o & width_mask;
  end
endmodule

// File: rtl/rol_barrel.sv
module rol_barrel
  import rol_flag_pkg::*;
(
  input  size_e             size_i,
  input  logic [MAX_W-1:0]  operand_i,
  input  logic [MCNT_W-1:0] amt_i,
  output logic [MAX_W-1:0]  result_o
);
  logic [MAX_W-1:0] rot_all [NUM_SZ];

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
    localparam int W  = MIN_W << k;
    localparam int LW = $clog2(W);
    logic [W-1:0] st [LW+1];

    assign st[0] = operand_i[W-1:0];
    for (genvar s = 0; s < LW; s++) begin : g_stage
      localparam int SH = 1 << s;
      assign st[s+1] = amt_i[s] ? {st[s][W-1-SH:0], st[s][W-1 -: SH]} : st[s];
    end
    assign rot_all[k] = MAX_W'(st[LW]);
  end

  assign result_o = rot_all[size_i];
endmodule

// File: rtl/rol_flag_gen.sv
module rol_flag_gen
  import rol_flag_pkg::*;
(
  input  size_e             size_i,
  input  logic [MCNT_W-1:0] masked_i,
  input  logic [MAX_W-1:0]  rot_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              we_o,
  output logic              undef_o
);
  logic msb;

  always_comb begin
    msb = rot_i[size_bits(size_i) - 1];
    carry_o = carry_i;
    ovf_o   = ovf_i;
    we_o    = 1'b0;
    undef_o = 1'b0;
    if (masked_i != '0) begin
      we_o    = 1'b1;
      carry_o = rot_i[0];
      if (masked_i == MCNT_W'(1)) ovf_o = rot_i[0] ^ msb;
      else                        undef_o = 1'b1;
    end
  end
endmodule

// File: rtl/rol_flag_unit.sv
module rol_flag_unit
  import rol_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [MAX_W-1:0]  operand_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  output logic              valid_o,
  output logic [MAX_W-1:0]  result_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              flags_we_o,
  output logic              ovf_undef_o
);
  size_e             size;
  logic [MCNT_W-1:0] masked, amt;
  logic [MAX_W-1:0]  rot;
  logic              c_n, o_n, we_n, u_n;

  assign size = size_e'(size_i);

  rol_count_mask u_mask (
    .size_i(size), .count_i(count_i), .masked_o(masked), .amt_o(amt)
  );

  rol_barrel u_rot (
    .size_i(size), .operand_i(operand_i), .amt_i(amt), .result_o(rot)
  );

  rol_flag_gen u_flag (
    .size_i(size), .masked_i(masked), .rot_i(rot), .carry_i(carry_i),
    .ovf_i(ovf_i), .carry_o(c_n), .ovf_o(o_n), .we_o(we_n), .undef_o(u_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      carry_o     <= 1'b0;
      ovf_o       <= 1'b0;
      flags_we_o  <= 1'b0;
      ovf_undef_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= rot;
        carry_o     <= c_n;
        ovf_o       <= o_n;
        flags_we_o  <= we_n;
        ovf_undef_o <= u_n;
      end
    end
  end

  assert_carry_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && flags_we_o |-> carry_o == result_o[0]);

  assert_no_undef_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !flags_we_o |-> !ovf_undef_o);

  assert_undef_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == SZ_B32 && count_i[4:0] > 5'd1 |=> ovf_undef_o && ovf_o == $past(ovf_i));

  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == SZ_B8 |=> result_o[MAX_W-1:MIN_W] == '0);

  assert_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i != SZ_B64 && count_i[4:0] == 5'd0 |=> !flags_we_o);

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o));
endmodule

// File: tb/sim_rol_flag_unit.sv
`timescale 1ns/1ps
module sim_rol_flag_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [1:0]  size_i = '0;
  logic [7:0]  count_i = '0;
  logic        carry_i = 1'b0, ovf_i = 1'b0;
  logic        valid_o, carry_o, ovf_o, flags_we_o, ovf_undef_o;
  logic [63:0] result_o;

  int total = 0, bad = 0;
  logic        pend = 1'b0;
  logic [63:0] e_res;
  logic        e_c, e_o, e_we, e_u;

  always #2.5 clk = ~clk;

  rol_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .operand_i(operand_i),
    .size_i(size_i), .count_i(count_i), .carry_i(carry_i), .ovf_i(ovf_i),
    .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o),
    .flags_we_o(flags_we_o), .ovf_undef_o(ovf_undef_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h size=%0d cnt=%0d", tag, act, exp, size_i, count_i);
    end
  endtask

  task automatic check_pending();
    chk("R9 valid", 64'(valid_o), 64'd1);
    chk("R1 R3 R4 result", result_o, e_res);
    chk("R5 R8 carry", 64'(carry_o), 64'(e_c));
    chk("R6 R7 R8 ovf", 64'(ovf_o), 64'(e_o));
    chk("R2 R5 R8 we", 64'(flags_we_o), 64'(e_we));
    chk("R7 undef", 64'(ovf_undef_o), 64'(e_u));
  endtask

  task automatic send(logic [63:0] op, logic [1:0] sz, logic [7:0] cnt, logic ci, logic oi);
    int w, m, a;
    logic [63:0] mask, v, r;
    @(negedge clk);
    if (pend) check_pending();
    valid_i = 1'b1; operand_i = op; size_i = sz; count_i = cnt; carry_i = ci; ovf_i = oi;
    w = 8 << sz;
    m = (sz == 2'd3) ? int'(cnt[5:0]) : int'(cnt[4:0]);
    a = m % w;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    v = op & mask;
    r = (a == 0) ? v : (((v << a) | (v >> (w - a))) & mask);
    e_res = r;
    if (m == 0) begin
      e_we = 1'b0; e_c = ci; e_o = oi; e_u = 1'b0;
    end else begin
      e_we = 1'b1; e_c = r[0];
      if (m == 1) begin e_o = r[0] ^ r[w-1]; e_u = 1'b0; end
      else        begin e_o = oi; e_u = 1'b1; end
    end
    pend = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", 64'(valid_o), 64'd0);
    chk("R10 result", result_o, 64'd0);
    chk("R10 flags", {60'd0, carry_o, ovf_o, flags_we_o, ovf_undef_o}, 64'd0);
    rst_ni = 1'b1;

    send(64'h0000_0000_0000_0081, 2'd0, 8'd1, 1'b0, 1'b0);   // R6 8-bit wrap
    send(64'hFFFF_FFFF_FFFF_FF5A, 2'd0, 8'd8, 1'b0, 1'b1);   // R3 count 8 on byte
    send(64'h1234_5678_9ABC_DEF0, 2'd0, 8'd32, 1'b1, 1'b1);  // R2 masked to 0
    send(64'h1234_5678_9ABC_DEF0, 2'd2, 8'd32, 1'b1, 1'b0);  // R2 masked to 0
    send(64'h8000_0000_0000_0000, 2'd3, 8'd64, 1'b1, 1'b0);  // R2 masked to 0
    send(64'h8000_0000_0000_0000, 2'd3, 8'd1, 1'b0, 1'b0);   // R6 64-bit

    for (int sz = 0; sz < 4; sz++)
      for (int c = 0; c < 256; c++)
        for (int k = 0; k < 3; k++) begin
          logic [63:0] op;
          case (k)
            0: op = {$urandom, $urandom};
            1: op = 64'hA5A5_0F0F_C3C3_8001 ^ {32'(c), 32'(sz)};
            default: op = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
          endcase
          send(op, 2'(sz), 8'(c), k[0], ^op[7:0]);
        end

    @(negedge clk);
    check_pending();
    pend = 1'b0;
    held = result_o;
    valid_i = 1'b0; operand_i = ~operand_i; count_i = 8'd3;
    @(negedge clk);
    chk("R9 valid drop", 64'(valid_o), 64'd0);
    chk("R9 hold", result_o, held);
    @(negedge clk);
    chk("R9 hold again", result_o, held);
    finish_run();
  end
endmodule